// File: doc/BRIEF.md
# Indirect Register Serial Bridge

This block lets a processor reach a small bank of remote 8-bit registers that are not on its bus. The processor sees two bus registers: a command register and a data register. Writing a command byte launches one serial transaction over a two-wire link, a serial clock and a serial data line. A write transaction copies the data register into the selected remote register. A read transaction fetches the selected remote register into the data register. Bit 0 of the command register readback is a busy flag that software polls until the transaction is over.

The remote side holds four registers. Address 0 and address 1 are configuration registers, address 2 is a monitor register, and address 3 is a read-only status register that mirrors six fault and event flags (supply monitor in bit 5, wake-up in bit 4, over-temperature in bit 3, transceiver short in bit 2, diagnostic-output short in bit 1, wake-pin short in bit 0). The serial clock is the system clock divided by 8, and a whole frame fits well inside the 10 µs bound that a 20.48 MHz system clock allows (205 cycles). A behavioural model of the remote bank is part of the block, so the three writable registers are visible as outputs.

Top module: `ireg_serial_bridge`

## Requirements
- R1: After reset the command readback and data readback are 0, the three remote register outputs are 0, and the serial clock is low.
- R2: A command byte with bit 7 = 0 and bits 6:2 = 0 writes the data register value into remote register bits 1:0 (0 = first configuration, 1 = second configuration, 2 = monitor); the output shows it by the time busy clears.
- R3: A command byte with bit 7 = 1 and bits 6:2 = 0 loads the addressed remote register into the data register in the same cycle busy clears.
- R4: Busy (command readback bit 0) reads 1 from the clock edge that accepts a command until exactly 88 cycles later, never longer than 205 cycles.
- R5: The serial clock is low while idle; in a frame it gives 11 rising edges, each high phase lasting 4 system cycles and each low phase 4 cycles.
- R6: The frame bits, taken at each serial clock rising edge, are in order: the read flag, address bit 1, address bit 0, then 8 data bits MSB first; on a read the remote side drives the 8 data bits.
- R7: A command written while busy is 1 is ignored: it starts nothing and changes no remote register.
- R8: A command byte with any of bits 6:2 set is ignored: busy stays 0 and no frame is sent.
- R9: Remote address 3 returns {2'b00, status flags input}; serial writes to address 3 are discarded and alter no other register.
- R10: Data register writes during a read do not change the returned value, and data register writes during a write do not change the value sent, which is the one present when the command was accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr_en | input | 1 | Bus write strobe, one cycle per write |
| bus_wr_sel | input | 1 | Bus write target: 0 = command register, 1 = data register |
| bus_wdata | input | 8 | Bus write data |
| bus_cmd_rd | output | 8 | Command register readback; bit 0 is busy, other bits 0 |
| bus_data_rd | output | 8 | Data register readback |
| stat_flags | input | 6 | Event and fault flags mirrored by remote status register |
| ser_clk | output | 1 | Serial link clock |
| ser_data | output | 1 | Serial link data line as seen by both ends |
| cfg0_q | output | 8 | Remote configuration register at address 0 |
| cfg1_q | output | 8 | Remote configuration register at address 1 |
| mon_q | output | 8 | Remote monitor register at address 2 |

## Verification
The assertions assume that the bus strobe is a single-cycle pulse sampled on the rising edge and that the serial clock seen by the remote model is only the one the bridge itself generates, so the remote bit counter stays aligned to frames. The bench keeps to this by driving every bus write for exactly one cycle from the falling edge and by sweeping all writable addresses with a set of data patterns, reading each back, then aiming commands at the busy window, the reserved bits and the status address. Status flags are changed only while the link is idle, so a read of address 3 has one well-defined expected value.

// File: rtl/isb_pkg.sv
// Shared constants and types for the indirect register serial bridge.
// Assumes a fixed four-entry remote bank addressed by two bits.
package isb_pkg;
    localparam int ADDR_W     = 2;
    localparam int NUM_REGS   = 1 << ADDR_W;
    localparam int STATUS_IDX = NUM_REGS - 1;
    localparam int NUM_RW     = NUM_REGS - 1;
    localparam int CMD_W      = 8;
    localparam int CMD_RD_BIT = 7;

    typedef enum logic {
        LINK_IDLE = 1'b0,
        LINK_XFER = 1'b1
    } link_state_t;

    // Total bits in one frame: read flag, address, data.
    function automatic int frame_len(input int data_w);
        return 1 + ADDR_W + data_w;
    endfunction
endpackage

// File: rtl/isb_sclk_gen.sv
// Serial clock generator. Divides the system clock by CLK_DIV while run_i
// is high, giving a 50% duty serial clock and one-cycle rise/fall ticks.
// Assumes CLK_DIV is even and at least 4; the clock idles low.
module isb_sclk_gen #(
    parameter int CLK_DIV = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    output logic rise_o,
    output logic fall_o,
    output logic sclk_o
);
    localparam int HALF  = CLK_DIV / 2;
    localparam int DIV_W = $clog2(CLK_DIV);

    logic [DIV_W-1:0] div_q;
    logic             sclk_q;
    logic [DIV_W:0]   hi_q;

    assign rise_o = run_i && (div_q == DIV_W'(HALF - 1));
    assign fall_o = run_i && (div_q == DIV_W'(CLK_DIV - 1));
    assign sclk_o = sclk_q;

    // Phase counter: free-runs modulo CLK_DIV during a frame.
    always_ff @(posedge clk) begin
        if (!rst_n || !run_i) begin
            div_q <= '0;
        end else if (div_q == DIV_W'(CLK_DIV - 1)) begin
            div_q <= '0;
        end else begin
            div_q <= div_q + 1'b1;
        end
    end

    // Serial clock level: high from the rise tick to the fall tick.
    always_ff @(posedge clk) begin
        if (!rst_n || !run_i) begin
            sclk_q <= 1'b0;
        end else if (rise_o) begin
            sclk_q <= 1'b1;
        end else if (fall_o) begin
            sclk_q <= 1'b0;
        end
    end

    // High-phase length tracker used by the checks below.
    always_ff @(posedge clk) begin
        if (!rst_n || !sclk_q) begin
            hi_q <= '0;
        end else begin
            hi_q <= hi_q + 1'b1;
        end
    end

    AST_SCLK_HIGH_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        sclk_q |-> (hi_q < (DIV_W+1)'(HALF))); // R5
    AST_SCLK_FALL_ON_TIME: assert property (@(posedge clk) disable iff (!rst_n)
        (sclk_q && (hi_q == (DIV_W+1)'(HALF - 1))) |=> !sclk_q); // R5
endmodule

// File: rtl/isb_master.sv
// Link master. Accepts one transaction at a time, shifts out the frame
// (read flag, address, data, MSB first) on the serial clock, and on reads
// samples the data line at each rising edge of the data phase.
// Assumes start_i is only raised while busy_o is low.
module isb_master
    import isb_pkg::*;
#(
    parameter int DATA_W  = 8,
    parameter int CLK_DIV = 8,
    parameter int LAT_MAX = 205
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              rd_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic              line_i,
    output logic              sclk_o,
    output logic              mdo_o,
    output logic              busy_o,
    output logic              done_o,
    output logic              rd_done_o,
    output logic [DATA_W-1:0] rdata_o
);
    localparam int FRAME_W = frame_len(DATA_W);
    localparam int HDR_W   = 1 + ADDR_W;
    localparam int CNT_W   = $clog2(FRAME_W);
    localparam int LAT_W   = $clog2(LAT_MAX + 1) + 1;

    link_state_t        state_q;
    logic [CNT_W-1:0]   bit_q;
    logic [FRAME_W-1:0] tx_q;
    logic [DATA_W-1:0]  rx_q;
    logic               rd_q;
    logic               rise_w;
    logic               fall_w;
    logic               last_w;
    logic [LAT_W-1:0]   lat_q;

    isb_sclk_gen #(.CLK_DIV(CLK_DIV)) u_sclk (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_i  (state_q == LINK_XFER),
        .rise_o (rise_w),
        .fall_o (fall_w),
        .sclk_o (sclk_o)
    );

    assign last_w    = (bit_q == CNT_W'(FRAME_W - 1));
    assign busy_o    = (state_q == LINK_XFER);
    assign done_o    = busy_o && fall_w && last_w;
    assign rd_done_o = done_o && rd_q;
    assign mdo_o     = tx_q[FRAME_W-1];
    assign rdata_o   = rx_q;

    // Frame sequencer: load on start, advance one bit per serial clock fall.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= LINK_IDLE;
            bit_q   <= '0;
            tx_q    <= '0;
            rd_q    <= 1'b0;
        end else begin
            case (state_q)
                LINK_IDLE: begin
                    if (start_i) begin
                        state_q <= LINK_XFER;
                        bit_q   <= '0;
                        rd_q    <= rd_i;
                        tx_q    <= {rd_i, addr_i, (rd_i ? {DATA_W{1'b0}} : wdata_i)};
                    end
                end
                LINK_XFER: begin
                    if (fall_w) begin
                        if (last_w) begin
                            state_q <= LINK_IDLE;
                            bit_q   <= '0;
                        end else begin
                            bit_q <= bit_q + 1'b1;
                            tx_q  <= {tx_q[FRAME_W-2:0], 1'b0};
                        end
                    end
                end
                default: state_q <= LINK_IDLE;
            endcase
        end
    end

    // Read capture: sample the line at rising edges of the data phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_q <= '0;
        end else if (rise_w && (bit_q >= CNT_W'(HDR_W))) begin
            rx_q <= {rx_q[DATA_W-2:0], line_i};
        end
    end

    // Transaction age counter, used only to bound the busy window.
    always_ff @(posedge clk) begin
        if (!rst_n || !busy_o) begin
            lat_q <= '0;
        end else begin
            lat_q <= lat_q + 1'b1;
        end
    end

    AST_BUSY_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> (lat_q < LAT_W'(LAT_MAX))); // R4
    AST_START_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |-> !busy_o); // R7
    AST_BIT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        bit_q < CNT_W'(FRAME_W)); // R6
endmodule

// File: rtl/isb_remote_bank.sv
// Behavioural model of the remote side. Watches the serial clock, shifts in
// the frame header, drives read data back on the line, and commits writes
// to the writable registers. The status register follows flags_i.
// Assumes the serial clock is the one produced by the matching master.
module isb_remote_bank
    import isb_pkg::*;
#(
    parameter int DATA_W  = 8,
    parameter int CLK_DIV = 8,
    parameter int FLAG_W  = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk_i,
    input  logic              line_i,
    input  logic [FLAG_W-1:0] flags_i,
    output logic              oe_o,
    output logic              do_o,
    output logic [DATA_W-1:0] reg_o [NUM_RW]
);
    localparam int FRAME_W = frame_len(DATA_W);
    localparam int HDR_W   = 1 + ADDR_W;
    localparam int CNT_W   = $clog2(FRAME_W);
    localparam int GAP_MAX = 2 * CLK_DIV;
    localparam int GAP_W   = $clog2(GAP_MAX + 1);

    logic                sclk_d;
    logic                rise_w;
    logic [CNT_W-1:0]    cnt_q;
    logic [FRAME_W-2:0]  sh_q;
    logic [DATA_W-1:0]   tx_q;
    logic                oe_q;
    logic                rd_q;
    logic [ADDR_W-1:0]   addr_q;
    logic [GAP_W-1:0]    gap_q;
    logic [DATA_W-1:0]   stat_q;
    logic [DATA_W-1:0]   bank_q [NUM_RW];
    logic [HDR_W-1:0]    hdr_w;
    logic                hdr_end_w;
    logic                frm_end_w;
    logic                gap_out_w;
    logic                commit_w;
    logic [DATA_W-1:0]   wdata_w;
    logic [DATA_W-1:0]   rsel_w;

    assign rise_w    = sclk_i && !sclk_d;
    assign hdr_w     = {sh_q[HDR_W-2:0], line_i};
    assign hdr_end_w = rise_w && (cnt_q == CNT_W'(HDR_W - 1));
    assign frm_end_w = rise_w && (cnt_q == CNT_W'(FRAME_W - 1));
    assign gap_out_w = (cnt_q != '0) && (gap_q == GAP_W'(GAP_MAX));
    assign wdata_w   = {sh_q[DATA_W-2:0], line_i};
    assign commit_w  = frm_end_w && !rd_q && (addr_q != ADDR_W'(STATUS_IDX));
    assign oe_o      = oe_q;
    assign do_o      = tx_q[DATA_W-1];

    // Read source selection over the whole bank, status at the top address.
    always_comb begin
        rsel_w = stat_q;
        for (int i = 0; i < NUM_RW; i++) begin
            if (hdr_w[ADDR_W-1:0] == ADDR_W'(i)) begin
                rsel_w = bank_q[i];
            end
        end
    end

    // Edge detector on the incoming serial clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sclk_d <= 1'b0;
        end else begin
            sclk_d <= sclk_i;
        end
    end

    // Bit counter and header shifter; a long silence re-aligns to a frame.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            sh_q   <= '0;
            gap_q  <= '0;
            rd_q   <= 1'b0;
            addr_q <= '0;
        end else if (rise_w) begin
            sh_q  <= {sh_q[FRAME_W-3:0], line_i};
            gap_q <= '0;
            cnt_q <= frm_end_w ? '0 : cnt_q + 1'b1;
            if (hdr_end_w) begin
                rd_q   <= hdr_w[HDR_W-1];
                addr_q <= hdr_w[ADDR_W-1:0];
            end
        end else if (gap_out_w) begin
            cnt_q <= '0;
            gap_q <= '0;
        end else if (cnt_q != '0) begin
            gap_q <= gap_q + 1'b1;
        end
    end

    // Read-back driver: enable after the header, shift one bit per rise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            oe_q <= 1'b0;
            tx_q <= '0;
        end else if (gap_out_w || frm_end_w) begin
            oe_q <= 1'b0;
        end else if (hdr_end_w) begin
            oe_q <= hdr_w[HDR_W-1];
            tx_q <= rsel_w;
        end else if (rise_w && oe_q) begin
            tx_q <= {tx_q[DATA_W-2:0], 1'b0};
        end
    end

    // Status register: mirrors the flag inputs, never written serially.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stat_q <= '0;
        end else begin
            stat_q <= DATA_W'(flags_i);
        end
    end

    // Writable registers, one per address below the status address.
    for (genvar g = 0; g < NUM_RW; g++) begin : g_rw
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                bank_q[g] <= '0;
            end else if (commit_w && (addr_q == ADDR_W'(g))) begin
                bank_q[g] <= wdata_w;
            end
        end
        assign reg_o[g] = bank_q[g];

        AST_STATUS_WRITE_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
            (frm_end_w && !rd_q && (addr_q == ADDR_W'(STATUS_IDX))) |=> $stable(bank_q[g])); // R9
    end

    AST_DRIVE_ONLY_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
        oe_q |-> rd_q); // R6
    AST_STATUS_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        stat_q[DATA_W-1:FLAG_W] == '0); // R9
endmodule

// File: rtl/ireg_serial_bridge.sv
// Top of the indirect register serial bridge. Holds the bus-side command
// and data registers, decodes command bytes, starts link transactions and
// loads read results. Contains the remote bank model on the same clock.
// Assumes bus_wr_en is a one-cycle strobe per bus write.
module ireg_serial_bridge
    import isb_pkg::*;
#(
    parameter int DATA_W  = 8,
    parameter int CLK_DIV = 8,
    parameter int LAT_MAX = 205,
    parameter int FLAG_W  = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr_en,
    input  logic              bus_wr_sel,
    input  logic [CMD_W-1:0]  bus_wdata,
    output logic [CMD_W-1:0]  bus_cmd_rd,
    output logic [DATA_W-1:0] bus_data_rd,
    input  logic [FLAG_W-1:0] stat_flags,
    output logic              ser_clk,
    output logic              ser_data,
    output logic [DATA_W-1:0] cfg0_q,
    output logic [DATA_W-1:0] cfg1_q,
    output logic [DATA_W-1:0] mon_q
);
    logic [DATA_W-1:0] data_q;
    logic              busy_w;
    logic              done_w;
    logic              rd_done_w;
    logic [DATA_W-1:0] rdata_w;
    logic              mdo_w;
    logic              rem_oe_w;
    logic              rem_do_w;
    logic              line_w;
    logic              rsv_clear_w;
    logic              cmd_wr_w;
    logic              data_wr_w;
    logic              start_w;
    logic [DATA_W-1:0] rem_regs_w [NUM_RW];

    assign rsv_clear_w = (bus_wdata[CMD_RD_BIT-1:ADDR_W] == '0);
    assign cmd_wr_w    = bus_wr_en && !bus_wr_sel;
    assign data_wr_w   = bus_wr_en && bus_wr_sel;
    assign start_w     = cmd_wr_w && rsv_clear_w && !busy_w;
    assign line_w      = rem_oe_w ? rem_do_w : mdo_w;

    assign bus_cmd_rd  = {{(CMD_W-1){1'b0}}, busy_w};
    assign bus_data_rd = data_q;
    assign ser_data    = line_w;
    assign cfg0_q      = rem_regs_w[0];
    assign cfg1_q      = rem_regs_w[1];
    assign mon_q       = rem_regs_w[2];

    // Data register: read results take priority over a same-cycle bus write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q <= '0;
        end else if (rd_done_w) begin
            data_q <= rdata_w;
        end else if (data_wr_w) begin
            data_q <= bus_wdata[DATA_W-1:0];
        end
    end

    isb_master #(
        .DATA_W  (DATA_W),
        .CLK_DIV (CLK_DIV),
        .LAT_MAX (LAT_MAX)
    ) u_master (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (start_w),
        .rd_i      (bus_wdata[CMD_RD_BIT]),
        .addr_i    (bus_wdata[ADDR_W-1:0]),
        .wdata_i   (data_q),
        .line_i    (line_w),
        .sclk_o    (ser_clk),
        .mdo_o     (mdo_w),
        .busy_o    (busy_w),
        .done_o    (done_w),
        .rd_done_o (rd_done_w),
        .rdata_o   (rdata_w)
    );

    isb_remote_bank #(
        .DATA_W  (DATA_W),
        .CLK_DIV (CLK_DIV),
        .FLAG_W  (FLAG_W)
    ) u_remote (
        .clk     (clk),
        .rst_n   (rst_n),
        .sclk_i  (ser_clk),
        .line_i  (line_w),
        .flags_i (stat_flags),
        .oe_o    (rem_oe_w),
        .do_o    (rem_do_w),
        .reg_o   (rem_regs_w)
    );

    AST_IDLE_CLOCK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_w |-> !ser_clk); // R5
    AST_REMOTE_DRIVES_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        rem_oe_w |-> busy_w); // R6
    AST_DATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(data_wr_w) && !$past(rd_done_w)) |-> $stable(data_q)); // R10
    AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        done_w |=> !busy_w); // R4
endmodule

// File: tb/sim_ireg_serial_bridge.sv
module sim_ireg_serial_bridge;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_wr_en = 1'b0;
    logic       bus_wr_sel = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_cmd_rd;
    logic [7:0] bus_data_rd;
    logic [5:0] stat_flags = 6'h00;
    logic       ser_clk;
    logic       ser_data;
    logic [7:0] cfg0_q;
    logic [7:0] cfg1_q;
    logic [7:0] mon_q;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    logic [7:0]  exp_reg [4];
    logic [10:0] fr_bits = '0;
    int          fr_rises = 0;
    int          hi_len = 0;
    int          hi_bad = 0;
    logic        sclk_prev = 1'b0;

    ireg_serial_bridge u0 (
        .clk         (clk),
        .rst_n       (rst_n),
        .bus_wr_en   (bus_wr_en),
        .bus_wr_sel  (bus_wr_sel),
        .bus_wdata   (bus_wdata),
        .bus_cmd_rd  (bus_cmd_rd),
        .bus_data_rd (bus_data_rd),
        .stat_flags  (stat_flags),
        .ser_clk     (ser_clk),
        .ser_data    (ser_data),
        .cfg0_q      (cfg0_q),
        .cfg1_q      (cfg1_q),
        .mon_q       (mon_q)
    );

    always #10 clk = ~clk;

    // Link monitor: frame bits at rising serial clock, high-phase lengths.
    always @(negedge clk) begin
        if (ser_clk) begin
            hi_len = hi_len + 1;
        end else begin
            if (hi_len != 0 && hi_len != 4) hi_bad = hi_bad + 1;
            hi_len = 0;
        end
        if (ser_clk && !sclk_prev) begin
            fr_bits  = {fr_bits[9:0], ser_data};
            fr_rises = fr_rises + 1;
        end
        sclk_prev = ser_clk;
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] out_of(input int a);
        case (a)
            0: return cfg0_q;
            1: return cfg1_q;
            default: return mon_q;
        endcase
    endfunction

    task automatic bus_wr(input logic sel, input logic [7:0] val);
        @(negedge clk);
        bus_wr_en  = 1'b1;
        bus_wr_sel = sel;
        bus_wdata  = val;
        @(negedge clk);
        bus_wr_en  = 1'b0;
    endtask

    task automatic wait_idle(output int n);
        n = 0;
        while (bus_cmd_rd[0] && n < 1000) begin
            @(negedge clk);
            n++;
        end
    endtask

    // Full write transaction with frame, clock and latency checks.
    task automatic wr_reg(input int a, input logic [7:0] val);
        int base;
        int lat;
        bus_wr(1'b1, val);
        base = fr_rises;
        bus_wr(1'b0, {6'b0, 2'(a)});
        chk("R4 busy set", 32'(bus_cmd_rd), 32'h1);
        wait_idle(lat);
        chk("R4 busy length", 32'(lat), 32'd88);
        chk("R5 rising edges", 32'(fr_rises - base), 32'd11);
        chk("R6 write frame", 32'(fr_bits), 32'({1'b0, 2'(a), val}));
        chk("R5 idle low", 32'(ser_clk), 32'h0);
        if (a < 3) begin
            exp_reg[a] = val;
            chk("R2 remote value", 32'(out_of(a)), 32'(val));
        end
    endtask

    // Full read transaction comparing the result with the model.
    task automatic rd_reg(input int a);
        int base;
        int lat;
        base = fr_rises;
        bus_wr(1'b0, {1'b1, 5'b0, 2'(a)});
        wait_idle(lat);
        chk("R4 read busy length", 32'(lat), 32'd88);
        chk("R3 read result", 32'(bus_data_rd), 32'(exp_reg[a]));
        chk("R6 read frame", 32'(fr_bits), 32'({1'b1, 2'(a), exp_reg[a]}));
        chk("R5 read rising edges", 32'(fr_rises - base), 32'd11);
    endtask

    initial begin
        repeat (2000000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        int lat;
        logic [7:0] pat;
        for (int i = 0; i < 4; i++) exp_reg[i] = 8'h00;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        chk("R1 cmd readback", 32'(bus_cmd_rd), 32'h0);
        chk("R1 data readback", 32'(bus_data_rd), 32'h0);
        chk("R1 cfg0", 32'(cfg0_q), 32'h0);
        chk("R1 cfg1", 32'(cfg1_q), 32'h0);
        chk("R1 mon", 32'(mon_q), 32'h0);
        chk("R1 serial clock", 32'(ser_clk), 32'h0);
        rd_reg(1);

        // R2 / R3 / R6: sweep writable addresses with patterns, read back
        for (int p = 0; p < 8; p++) begin
            for (int a = 0; a < 3; a++) begin
                case (p)
                    0: pat = 8'h00;
                    1: pat = 8'hFF;
                    2: pat = 8'hA5;
                    3: pat = 8'h5A;
                    4: pat = 8'h01;
                    5: pat = 8'h80;
                    default: pat = 8'((p * 53 + a * 37 + 11) % 256);
                endcase
                wr_reg(a, pat);
            end
            for (int a = 0; a < 3; a++) rd_reg(a);
        end

        // R9: status register mirrors flags and ignores serial writes
        wr_reg(0, 8'h3C);
        wr_reg(1, 8'hC3);
        wr_reg(2, 8'h99);
        stat_flags = 6'h2B;
        repeat (3) @(negedge clk);
        exp_reg[3] = 8'h2B;
        rd_reg(3);
        wr_reg(3, 8'hFF);
        chk("R9 cfg0 untouched", 32'(cfg0_q), 32'h3C);
        chk("R9 cfg1 untouched", 32'(cfg1_q), 32'hC3);
        chk("R9 mon untouched", 32'(mon_q), 32'h99);
        rd_reg(3);
        stat_flags = 6'h3F;
        repeat (3) @(negedge clk);
        exp_reg[3] = 8'h3F;
        rd_reg(3);
        stat_flags = 6'h00;
        repeat (3) @(negedge clk);
        exp_reg[3] = 8'h00;
        rd_reg(3);

        // R7: command during busy is ignored
        bus_wr(1'b1, 8'h4E);
        bus_wr(1'b0, 8'h00);
        repeat (20) @(negedge clk);
        bus_wr(1'b0, 8'h01);
        bus_wr(1'b0, 8'h82);
        wait_idle(lat);
        chk("R7 first write landed", 32'(cfg0_q), 32'h4E);
        exp_reg[0] = 8'h4E;
        @(negedge clk);
        chk("R7 no queued start", 32'(bus_cmd_rd), 32'h0);
        repeat (100) @(negedge clk);
        chk("R7 cfg1 unchanged", 32'(cfg1_q), 32'hC3);
        chk("R7 data not overwritten", 32'(bus_data_rd), 32'h4E);

        // R8: reserved bits set reject the command
        bus_wr(1'b1, 8'hE7);
        for (int b = 2; b < 7; b++) begin
            int base;
            base = fr_rises;
            bus_wr(1'b0, 8'(1 << b));
            chk("R8 busy stays low", 32'(bus_cmd_rd), 32'h0);
            repeat (100) @(negedge clk);
            chk("R8 no frame", 32'(fr_rises - base), 32'h0);
            chk("R8 cfg0 unchanged", 32'(cfg0_q), 32'h4E);
        end

        // R10: data writes during a read and during a write
        bus_wr(1'b0, 8'h81);
        repeat (30) @(negedge clk);
        bus_wr(1'b1, 8'hEE);
        wait_idle(lat);
        chk("R10 read result intact", 32'(bus_data_rd), 32'hC3);
        bus_wr(1'b1, 8'h96);
        bus_wr(1'b0, 8'h02);
        repeat (30) @(negedge clk);
        bus_wr(1'b1, 8'h69);
        wait_idle(lat);
        chk("R10 sent value latched", 32'(mon_q), 32'h96);
        chk("R10 data register kept", 32'(bus_data_rd), 32'h69);

        chk("R5 high phase length", 32'(hi_bad), 32'h0);

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule